// File: doc/BRIEF.md
# ALU Status Flag Generator

This block derives the condition flags of an 8-bit or 16-bit arithmetic or logic operation and keeps them, together with three machine-control bits, in one 16-bit flag word. The ALU itself lives elsewhere. It presents both operands, its result, its carry or borrow out of the top bit of the selected width, an operation class and a width select. The block turns these into zero, sign, parity, auxiliary carry, carry and overflow. It latches them on the clock edge where the update enable is high.

The direction, interrupt-enable and single-step bits share the same word. Control logic writes each of them through its own write enable and value pin. Those writes are independent of the condition update and of each other. The registered flag word is the only output. It changes one clock edge after the inputs that cause the change.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset the flag word is 0x0000. The bit layout is fixed: carry bit 0, parity bit 2, auxiliary carry bit 4, zero bit 6, sign bit 7, single-step bit 8, interrupt-enable bit 9, direction bit 10, overflow bit 11. Bits 1, 3, 5 and 12 to 15 always read zero.
- R2: On an update, zero (bit 6) is set exactly when the result bits of the selected width are all zero. Width select `wide`=1 means 16 bits and 0 means 8 bits.
- R3: On an update, sign (bit 7) equals the top bit of the result at the selected width: bit 15 when wide, bit 7 when narrow.
- R4: On an update, parity (bit 2) is set when result bits 7:0 hold an even number of ones, at either width.
- R5: On an add (class 0) or subtract (class 1) update, auxiliary carry (bit 4) is set on a carry or borrow between bit 3 and bit 4, that is opA[4]^opB[4]^result[4].
- R6: On an add or subtract update, carry (bit 0) takes `carryOut`. On a logic update (class 2), carry and overflow are cleared, `carryOut` is ignored, and auxiliary carry keeps its value.
- R7: On an add update, overflow (bit 11) is set when both operands share a top bit and the result's top bit differs from it. On a subtract update, it is set when the operands' top bits differ and the result's top bit differs from opA's.
- R8: The six condition bits change only on a clock edge where `updEn` is high and the class is 0, 1 or 2. Class 3 is reserved and leaves them unchanged.
- R9: Each control bit loads its value pin on an edge where its write enable is high, whatever `updEn` is. Otherwise it holds, and condition updates never alter it.
- R10: In 8-bit mode, operand and result bits 15:8 have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | First ALU operand |
| opB | input | 16 | Second ALU operand |
| result | input | 16 | ALU result |
| carryOut | input | 1 | Carry (add) or borrow (subtract) out of the top bit of the selected width |
| opClass | input | 2 | 0 add, 1 subtract, 2 logic, 3 reserved |
| wide | input | 1 | 1 selects 16-bit width, 0 selects 8-bit |
| updEn | input | 1 | Load the condition flags this cycle |
| dirWe | input | 1 | Write enable for the direction bit |
| dirVal | input | 1 | Value for the direction bit |
| intWe | input | 1 | Write enable for the interrupt-enable bit |
| intVal | input | 1 | Value for the interrupt-enable bit |
| trapWe | input | 1 | Write enable for the single-step bit |
| trapVal | input | 1 | Value for the single-step bit |
| flagWord | output | 16 | Registered flag word |

## Verification
The assertions assume that `result` and `carryOut` are consistent with the operands at the selected width. The parity and hold properties need only that the inputs are stable across the sampling edge. The bench therefore builds each result and carry in its own model from the operands and class, so that the presented values are always a true sum, difference or AND. In narrow mode it places a fixed unrelated pattern in the upper result byte and the upper operand bytes, which keeps the inputs valid while the high bits vary. For logic operations it drives `carryOut` high, so that the clearing of carry is visible.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int DATA_W   = 16;
  localparam int NARROW_W = 8;
  localparam int FLAG_W   = 16;
  localparam int AUX_BIT  = 4;          // carry into this bit = carry out of bit 3

  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_TF = 8;
  localparam int POS_IF = 9;
  localparam int POS_DF = 10;
  localparam int POS_OF = 11;

  localparam logic [FLAG_W-1:0] USED_MASK =
    FLAG_W'((1 << POS_CF) | (1 << POS_PF) | (1 << POS_AF) | (1 << POS_ZF) |
            (1 << POS_SF) | (1 << POS_TF) | (1 << POS_IF) | (1 << POS_DF) |
            (1 << POS_OF));

  typedef enum logic [1:0] {
    CLS_ADD   = 2'd0,
    CLS_SUB   = 2'd1,
    CLS_LOGIC = 2'd2,
    CLS_RSVD  = 2'd3
  } opClass_e;

  typedef struct packed {
    logic loadCond;
    logic arith;
    logic subtract;
    logic wide;
    logic loadDir;
    logic dirVal;
    logic loadInt;
    logic intVal;
    logic loadTrap;
    logic trapVal;
  } flagStrb_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic [1:0] opClass,
  input  logic       wide,
  input  logic       updEn,
  input  logic       dirWe,
  input  logic       dirVal,
  input  logic       intWe,
  input  logic       intVal,
  input  logic       trapWe,
  input  logic       trapVal,
  output flagStrb_t  strb
);
  opClass_e cls;

  always_comb begin
    cls = opClass_e'(opClass);
    strb = '0;
    strb.wide     = wide;
    strb.arith    = (cls == CLS_ADD) || (cls == CLS_SUB);
    strb.subtract = (cls == CLS_SUB);
    strb.loadCond = updEn && (cls != CLS_RSVD);
    strb.loadDir  = dirWe;
    strb.dirVal   = dirVal;
    strb.loadInt  = intWe;
    strb.intVal   = intVal;
    strb.loadTrap = trapWe;
    strb.trapVal  = trapVal;
  end
endmodule

// File: rtl/flag_dp.sv
module flag_dp
  import flag_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NW = NARROW_W,
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  flagStrb_t     strb,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic [DW-1:0] result,
  input  logic          carryOut,
  output logic [FW-1:0] flagWord
);
  localparam int TOP_W = DW - 1;
  localparam int TOP_N = NW - 1;

  logic cfQ, pfQ, afQ, zfQ, sfQ, ofQ;
  logic tfQ, ifQ, dfQ;
  logic cfNext, pfNext, afNext, zfNext, sfNext, ofNext;
  logic resTop, aTop, bTop;

  // pick the top bits and zero test for the active width
  always_comb begin
    if (strb.wide) begin
      resTop = result[TOP_W];
      aTop   = opA[TOP_W];
      bTop   = opB[TOP_W];
      zfNext = (result == '0);
    end else begin
      resTop = result[TOP_N];
      aTop   = opA[TOP_N];
      bTop   = opB[TOP_N];
      zfNext = (result[NW-1:0] == '0);
    end
    sfNext = resTop;
    pfNext = ~^result[NW-1:0];
    afNext = strb.arith ? (opA[AUX_BIT] ^ opB[AUX_BIT] ^ result[AUX_BIT]) : afQ;
    cfNext = strb.arith & carryOut;
    ofNext = strb.arith && (resTop != aTop) &&
             (strb.subtract ? (aTop != bTop) : (aTop == bTop));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {cfQ, pfQ, afQ, zfQ, sfQ, ofQ} <= '0;
    end else if (strb.loadCond) begin
      cfQ <= cfNext;
      pfQ <= pfNext;
      afQ <= afNext;
      zfQ <= zfNext;
      sfQ <= sfNext;
      ofQ <= ofNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {tfQ, ifQ, dfQ} <= '0;
    end else begin
      if (strb.loadDir)  dfQ <= strb.dirVal;
      if (strb.loadInt)  ifQ <= strb.intVal;
      if (strb.loadTrap) tfQ <= strb.trapVal;
    end
  end

  always_comb begin
    flagWord = '0;
    flagWord[POS_CF] = cfQ;
    flagWord[POS_PF] = pfQ;
    flagWord[POS_AF] = afQ;
    flagWord[POS_ZF] = zfQ;
    flagWord[POS_SF] = sfQ;
    flagWord[POS_TF] = tfQ;
    flagWord[POS_IF] = ifQ;
    flagWord[POS_DF] = dfQ;
    flagWord[POS_OF] = ofQ;
  end

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (flagWord & ~USED_MASK) == '0);

  a_r8_cond_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCond |=> $stable({cfQ, pfQ, afQ, zfQ, sfQ, ofQ}));

  a_r6_logic_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadCond && !strb.arith) |=> (!cfQ && !ofQ && $stable(afQ)));

  a_r4_parity_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCond |=> (pfQ == ~^$past(result[NW-1:0])));

  a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadDir || strb.loadInt || strb.loadTrap) |=> $stable({dfQ, ifQ, tfQ}));

  a_r9_dir_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDir |=> (dfQ == $past(strb.dirVal)));
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic              carryOut,
  input  logic [1:0]        opClass,
  input  logic              wide,
  input  logic              updEn,
  input  logic              dirWe,
  input  logic              dirVal,
  input  logic              intWe,
  input  logic              intVal,
  input  logic              trapWe,
  input  logic              trapVal,
  output logic [FLAG_W-1:0] flagWord
);
  flagStrb_t strb;

  flag_ctrl u_ctrl (
    .opClass (opClass),
    .wide    (wide),
    .updEn   (updEn),
    .dirWe   (dirWe),
    .dirVal  (dirVal),
    .intWe   (intWe),
    .intVal  (intVal),
    .trapWe  (trapWe),
    .trapVal (trapVal),
    .strb    (strb)
  );

  flag_dp #(.DW(DATA_W), .NW(NARROW_W), .FW(FLAG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .carryOut (carryOut),
    .flagWord (flagWord)
  );
endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0, result = '0;
  logic        carryOut = 1'b0;
  logic [1:0]  opClass = 2'd0;
  logic        wide = 1'b1, updEn = 1'b0;
  logic        dirWe = 1'b0, dirVal = 1'b0, intWe = 1'b0, intVal = 1'b0;
  logic        trapWe = 1'b0, trapVal = 1'b0;
  logic [15:0] flagWord;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .result(result),
    .carryOut(carryOut), .opClass(opClass), .wide(wide), .updEn(updEn),
    .dirWe(dirWe), .dirVal(dirVal), .intWe(intWe), .intVal(intVal),
    .trapWe(trapWe), .trapVal(trapVal), .flagWord(flagWord)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {wide, class, opA, opB}
  localparam int NV = 10;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 2'd0, 16'h7FFF, 16'h0001},
    {1'b1, 2'd0, 16'hFFFF, 16'h0001},
    {1'b1, 2'd1, 16'h0000, 16'h0001},
    {1'b1, 2'd1, 16'h8000, 16'h0001},
    {1'b1, 2'd2, 16'hF0F0, 16'h0F0F},
    {1'b0, 2'd0, 16'h127F, 16'h3401},
    {1'b0, 2'd1, 16'hAB10, 16'hCD01},
    {1'b0, 2'd0, 16'h55C3, 16'h00A5},
    {1'b1, 2'd1, 16'h1234, 16'h1234},
    {1'b0, 2'd2, 16'hFF3C, 16'h00FF}
  };

  function automatic void model(input logic w, input logic [1:0] c,
                                input logic [15:0] a, input logic [15:0] b,
                                input logic afPrev,
                                output logic [15:0] r, output logic co,
                                output logic [15:0] f);
    logic [16:0] s17;
    logic [8:0]  s9;
    logic        rt, at, bt;
    f = '0;
    if (w) begin
      s17 = (c == 2'd1) ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
      r  = (c == 2'd2) ? (a & b) : s17[15:0];
      co = (c == 2'd2) ? 1'b1 : s17[16];
      rt = r[15]; at = a[15]; bt = b[15];
      f[6] = (r == 16'h0);
    end else begin
      s9 = (c == 2'd1) ? ({1'b0, a[7:0]} - {1'b0, b[7:0]}) : ({1'b0, a[7:0]} + {1'b0, b[7:0]});
      r  = {8'hA5, (c == 2'd2) ? (a[7:0] & b[7:0]) : s9[7:0]};
      co = (c == 2'd2) ? 1'b1 : s9[8];
      rt = r[7]; at = a[7]; bt = b[7];
      f[6] = (r[7:0] == 8'h0);
    end
    f[7] = rt;
    f[2] = ~^r[7:0];
    f[4] = (c == 2'd2) ? afPrev : (a[4] ^ b[4] ^ r[4]);
    f[0] = (c == 2'd2) ? 1'b0 : co;
    if (c == 2'd0)      f[11] = (at == bt) && (rt != at);
    else if (c == 2'd1) f[11] = (at != bt) && (rt != at);
    else                f[11] = 1'b0;
  endfunction

  task automatic applyOp(input logic w, input logic [1:0] c,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] r, input logic co, input logic en);
    @(negedge clk);
    wide = w; opClass = c; opA = a; opB = b; result = r; carryOut = co; updEn = en;
    @(negedge clk);
    updEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] r, f;
    logic co, afModel;
    afModel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset value", flagWord, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", flagWord, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      model(VEC[i][34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0], afModel, r, co, f);
      applyOp(VEC[i][34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0], r, co, 1'b1);
      afModel = f[4];
      chk("R1 unused bits", flagWord & 16'hF02A, 16'h0000);
      chk("R2 zero", {15'd0, flagWord[6]}, {15'd0, f[6]});
      chk("R3 sign", {15'd0, flagWord[7]}, {15'd0, f[7]});
      chk("R4 parity", {15'd0, flagWord[2]}, {15'd0, f[2]});
      chk("R5 aux carry", {15'd0, flagWord[4]}, {15'd0, f[4]});
      chk("R6 carry", {15'd0, flagWord[0]}, {15'd0, f[0]});
      chk("R7 overflow", {15'd0, flagWord[11]}, {15'd0, f[11]});
      if (!VEC[i][34]) chk("R10 narrow word", flagWord, f);
    end

    // 8-bit 0x0F + 0x01 = 0x10: only aux carry
    applyOp(1'b0, 2'd0, 16'h000F, 16'h0001, 16'hA510, 1'b0, 1'b1);
    chk("R5 nibble carry", flagWord, 16'h0010);
    // logic giving zero keeps aux carry, ignores carryOut
    applyOp(1'b0, 2'd2, 16'h00FF, 16'h0000, 16'hA500, 1'b1, 1'b1);
    chk("R6 logic keeps AF", flagWord, 16'h0054);
    // no update enable
    applyOp(1'b1, 2'd0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0);
    chk("R8 updEn low holds", flagWord, 16'h0054);
    // reserved class
    applyOp(1'b1, 2'd3, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1);
    chk("R8 reserved class holds", flagWord, 16'h0054);

    // control bits
    @(negedge clk);
    dirWe = 1'b1; dirVal = 1'b1; intWe = 1'b1; intVal = 1'b1; trapWe = 1'b1; trapVal = 1'b1;
    @(negedge clk);
    dirWe = 1'b0; intWe = 1'b0; trapWe = 1'b0;
    chk("R9 control set", flagWord, 16'h0754);
    applyOp(1'b1, 2'd0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1);
    chk("R9 control survives update", flagWord, 16'h0F94);
    @(negedge clk);
    dirWe = 1'b1; dirVal = 1'b0; trapVal = 1'b0;
    @(negedge clk);
    dirWe = 1'b0;
    chk("R9 direction clear only", flagWord, 16'h0B94);

    // narrow with varied upper bytes
    applyOp(1'b0, 2'd0, 16'h1280, 16'h3480, 16'hA500, 1'b1, 1'b1);
    chk("R10 upper bytes ignored", flagWord, 16'h0B45);

    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset clears all", flagWord, 16'h0000);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule